// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel NOR-style flash device. Bus write cycles deliver a command byte in the low eight data bits, together with an address. From these writes the block chooses what a read returns: the array, the status word, the identifier codes, or the margin-verify path. It also launches program and erase jobs on an abstract write engine, which answers with busy, done and fail signals. Flag storage lives in a separate status block. This controller only sends it set and clear pulses.

Program and erase both take two writes: a setup command followed by a confirm. The first write stages the operation and the second launches it. A confirm that does not match the setup, or one issued while the programming supply is out of range, produces error pulses and locks the controller to a small command set. The automatic block erase opens a collection window that accepts further block addresses until the bus stays quiet for a fixed time. While an erase job runs, it can be suspended and later resumed. For a multi-block erase, suspend is only accepted after a settle time has passed since the last address was loaded. Both time windows are cycle counters derived from the clock frequency.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_mode_o is 0 (array), susp_o is 0, and no job pulse, push pulse or flag pulse is present.
- R2: When idle and unlocked, these commands set rd_mode_o as follows: FFh gives 0 (array), 70h gives 1 (status), 90h gives 2 (identifier), A0h gives 3 (verify). A0h also latches the write address on job_addr_o. In identifier mode, id_sel_i=0 selects the manufacturer code and id_sel_i=1 selects the device code. Either code is zero-extended to the data width on id_data_o.
- R3: 10h or 40h stages a program. The next write then pulses job_start_o with job_kind_o=0, and with that write's address and data on job_addr_o and job_data_o. If that next write is FFh instead, the program is aborted: rd_mode_o becomes 0 and no job starts.
- R4: Three erase pairs each pulse job_start_o, with the confirm write's address on job_addr_o. 20h then 20h starts job_kind_o=1 (chip erase). 60h then 60h starts job_kind_o=2 (block erase). 30h then 30h starts job_kind_o=3 (automatic chip erase).
- R5: After any erase setup, two consecutive FFh writes abort it: rd_mode_o becomes 0 and nothing starts. Any other write that is not the matching confirm pulses set_prog_fail_o and set_erase_fail_o together, sets rd_mode_o to 1 and locks the controller.
- R6: 20h followed by D0h opens the block-address window. The D0h write and every later write accepted in the window each pulse blk_push_o with their address. A write is accepted if it is sampled within LOAD_CYC-1 cycles of the previous one. job_start_o with job_kind_o=4 pulses exactly LOAD_CYC cycles after the last accepted address.
- R7: While a program job runs, every write is ignored. While an erase job runs, B0h (suspend) is the only write that has any effect.
- R8: B0h during a running erase raises susp_o and sets rd_mode_o to 1. For kind 4, B0h is only accepted once HOLD_CYC-1 cycles have passed since the last address load. While suspended, only FFh, 70h and D0h have an effect, and D0h drops susp_o. D0h has no effect when nothing is suspended.
- R9: While locked, only 50h, 70h and FFh are accepted. 50h pulses clr_status_o and removes the lock.
- R10: While vpp_lockout_i is high, every write is ignored.
- R11: If vpp_ok_i is low when a confirm or program-data write arrives, no job starts. Instead, set_vpp_fail_o pulses together with set_erase_fail_o (for an erase) or set_prog_fail_o (for a program), and the controller locks.
- R12: When job_done_i arrives, the controller returns to idle with rd_mode_o=1. If job_fail_i is also high, the fail pulse matching the job type is raised and the controller locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data; bits 7:0 carry the command |
| vpp_lockout_i | input | 1 | Programming supply below lockout level |
| vpp_ok_i | input | 1 | Programming supply within operating range |
| id_sel_i | input | 1 | Read address bit 0 for identifier select |
| job_busy_i | input | 1 | Write engine is running a job |
| job_done_i | input | 1 | Write engine finished a job (pulse) |
| job_fail_i | input | 1 | Finished job failed, valid with job_done_i |
| rd_mode_o | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 verify |
| id_data_o | output | DATA_W | Identifier code for the current id_sel_i |
| job_start_o | output | 1 | Start pulse to the write engine |
| job_kind_o | output | 3 | Job type: 0 program, 1 chip, 2 block, 3 auto chip, 4 auto block |
| job_addr_o | output | ADDR_W | Job or verify address |
| job_data_o | output | DATA_W | Program data |
| blk_push_o | output | 1 | Block address load pulse in the collection window |
| susp_o | output | 1 | Erase suspended |
| set_prog_fail_o | output | 1 | Set program-fail flag (pulse) |
| set_erase_fail_o | output | 1 | Set erase-fail flag (pulse) |
| set_vpp_fail_o | output | 1 | Set supply-fail flag (pulse) |
| clr_status_o | output | 1 | Clear status flags (pulse) |

## Verification
A wrong sequencing state first shows up on the first write after it. The next edge then produces a wrong job_start_o or fail pulse, or a wrong rd_mode_o, so the bench checks those one cycle after each write. A stuck lock or a leftover pending FFh shows up as a command that is ignored or misread. A timer error moves the job start or the first accepted suspend by a cycle count, so the window edges are sampled on both sides: at the last cycle before the start and at the start itself.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_VERIFY = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    JOB_PROG      = 3'd0,
    JOB_CHIP_ERS  = 3'd1,
    JOB_BLK_ERS   = 3'd2,
    JOB_AUTO_CHIP = 3'd3,
    JOB_AUTO_BLK  = 3'd4
  } job_kind_e;

  typedef enum logic [3:0] {
    CMD_READ_ARRAY,
    CMD_PGM_SETUP,
    CMD_ERS_20,
    CMD_BLK_60,
    CMD_AUTO_30,
    CMD_VERIFY,
    CMD_IDENT,
    CMD_SUSPEND,
    CMD_CONFIRM_D0,
    CMD_STATUS,
    CMD_CLEAR,
    CMD_OTHER
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PGM_SETUP,
    ST_ERS_SETUP,
    ST_BLK_SETUP,
    ST_AUTO_SETUP,
    ST_LOAD,
    ST_PGM_BUSY,
    ST_ERS_BUSY,
    ST_SUSP
  } state_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (code_i)
      8'hFF:        cmd_o = CMD_READ_ARRAY;
      8'h10, 8'h40: cmd_o = CMD_PGM_SETUP;
      8'h20:        cmd_o = CMD_ERS_20;
      8'h60:        cmd_o = CMD_BLK_60;
      8'h30:        cmd_o = CMD_AUTO_30;
      8'hA0:        cmd_o = CMD_VERIFY;
      8'h90:        cmd_o = CMD_IDENT;
      8'hB0:        cmd_o = CMD_SUSPEND;
      8'hD0:        cmd_o = CMD_CONFIRM_D0;
      8'h70:        cmd_o = CMD_STATUS;
      8'h50:        cmd_o = CMD_CLEAR;
      default:      cmd_o = CMD_OTHER;
    endcase
  end
endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
  parameter int unsigned LIMIT = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // saturating count of cycles since the last clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = (cnt_q == LAST);

  // R6
  gap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expired_o);
endmodule

// File: rtl/flash_id_sel.sv
module flash_id_sel #(
  parameter int unsigned DATA_W   = 16,
  parameter logic [7:0]  MFR_CODE = 8'hA5,
  parameter logic [7:0]  DEV_CODE = 8'h3C
) (
  input  logic              sel_i,
  output logic [DATA_W-1:0] id_o
);
  logic [7:0] code;
  assign code = sel_i ? DEV_CODE : MFR_CODE;
  assign id_o = {{(DATA_W-8){1'b0}}, code};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned LOAD_US  = 30,
  parameter int unsigned HOLD_US  = 100,
  parameter logic [7:0]  MFR_CODE = 8'hA5,
  parameter logic [7:0]  DEV_CODE = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              vpp_lockout_i,
  input  logic              vpp_ok_i,
  input  logic              id_sel_i,
  input  logic              job_busy_i,
  input  logic              job_done_i,
  input  logic              job_fail_i,
  output logic [1:0]        rd_mode_o,
  output logic [DATA_W-1:0] id_data_o,
  output logic              job_start_o,
  output logic [2:0]        job_kind_o,
  output logic [ADDR_W-1:0] job_addr_o,
  output logic [DATA_W-1:0] job_data_o,
  output logic              blk_push_o,
  output logic              susp_o,
  output logic              set_prog_fail_o,
  output logic              set_erase_fail_o,
  output logic              set_vpp_fail_o,
  output logic              clr_status_o
);
  localparam int unsigned LOAD_CYC = CLK_MHZ * LOAD_US;
  localparam int unsigned HOLD_CYC = CLK_MHZ * HOLD_US;

  cmd_e      cmd;
  state_e    state_q, state_d;
  rd_mode_e  mode_q, mode_d;
  job_kind_e kind_q, kind_d, cfm_kind;
  logic      lock_q, lock_d, ff_q, ff_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic start_q, start_d, push_q, push_d;
  logic pf_q, pf_d, ef_q, ef_d, vf_q, vf_d, clr_q, clr_d;
  logic load_clr, gap_expired, hold_expired, wr_ok, cfm_hit, susp_ok;

  flash_cmd_decode u_decode (
    .code_i (wr_data_i[7:0]),
    .cmd_o  (cmd)
  );

  flash_gap_timer #(.LIMIT(LOAD_CYC)) u_gap_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load_clr),
    .expired_o (gap_expired)
  );

  flash_gap_timer #(.LIMIT(HOLD_CYC)) u_hold_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load_clr),
    .expired_o (hold_expired)
  );

  flash_id_sel #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id_sel (
    .sel_i (id_sel_i),
    .id_o  (id_data_o)
  );

  assign wr_ok   = wr_i && !vpp_lockout_i;
  assign susp_ok = job_busy_i && ((kind_q != JOB_AUTO_BLK) || hold_expired);

  // confirm matching for each erase setup state
  always_comb begin
    cfm_hit  = 1'b0;
    cfm_kind = JOB_CHIP_ERS;
    unique case (state_q)
      ST_ERS_SETUP: begin
        if (cmd == CMD_ERS_20) begin
          cfm_hit = 1'b1; cfm_kind = JOB_CHIP_ERS;
        end else if (cmd == CMD_CONFIRM_D0) begin
          cfm_hit = 1'b1; cfm_kind = JOB_AUTO_BLK;
        end
      end
      ST_BLK_SETUP: begin
        cfm_hit = (cmd == CMD_BLK_60); cfm_kind = JOB_BLK_ERS;
      end
      ST_AUTO_SETUP: begin
        cfm_hit = (cmd == CMD_AUTO_30); cfm_kind = JOB_AUTO_CHIP;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q; mode_d = mode_q; kind_d = kind_q;
    lock_d  = lock_q;  ff_d   = ff_q;
    addr_d  = addr_q;  data_d = data_q;
    start_d = 1'b0; push_d = 1'b0; load_clr = 1'b0;
    pf_d = 1'b0; ef_d = 1'b0; vf_d = 1'b0; clr_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (wr_ok && (!lock_q || cmd inside {CMD_READ_ARRAY, CMD_STATUS, CMD_CLEAR})) begin
          ff_d = 1'b0;
          unique case (cmd)
            CMD_READ_ARRAY: mode_d = RD_ARRAY;
            CMD_STATUS:     mode_d = RD_STATUS;
            CMD_IDENT:      mode_d = RD_IDENT;
            CMD_VERIFY: begin
              mode_d = RD_VERIFY; addr_d = wr_addr_i;
            end
            CMD_CLEAR: begin
              clr_d = 1'b1; lock_d = 1'b0;
            end
            CMD_PGM_SETUP: state_d = ST_PGM_SETUP;
            CMD_ERS_20:    state_d = ST_ERS_SETUP;
            CMD_BLK_60:    state_d = ST_BLK_SETUP;
            CMD_AUTO_30:   state_d = ST_AUTO_SETUP;
            default: ;
          endcase
        end
      end
      ST_PGM_SETUP: begin
        if (wr_ok) begin
          state_d = ST_IDLE;
          if (cmd == CMD_READ_ARRAY) begin
            mode_d = RD_ARRAY;
          end else if (!vpp_ok_i) begin
            pf_d = 1'b1; vf_d = 1'b1; lock_d = 1'b1; mode_d = RD_STATUS;
          end else begin
            start_d = 1'b1; kind_d = JOB_PROG; state_d = ST_PGM_BUSY;
            addr_d = wr_addr_i; data_d = wr_data_i; mode_d = RD_STATUS;
          end
        end
      end
      ST_ERS_SETUP, ST_BLK_SETUP, ST_AUTO_SETUP: begin
        if (wr_ok) begin
          if (cmd == CMD_READ_ARRAY) begin
            // the second FFh in a row aborts the staged erase
            if (ff_q) begin
              state_d = ST_IDLE; mode_d = RD_ARRAY; ff_d = 1'b0;
            end else begin
              ff_d = 1'b1;
            end
          end else if (cfm_hit && !ff_q) begin
            ff_d = 1'b0; mode_d = RD_STATUS;
            if (!vpp_ok_i) begin
              ef_d = 1'b1; vf_d = 1'b1; lock_d = 1'b1; state_d = ST_IDLE;
            end else begin
              kind_d = cfm_kind; addr_d = wr_addr_i;
              if (cfm_kind == JOB_AUTO_BLK) begin
                state_d = ST_LOAD; push_d = 1'b1; load_clr = 1'b1;
              end else begin
                state_d = ST_ERS_BUSY; start_d = 1'b1;
              end
            end
          end else begin
            ff_d = 1'b0; pf_d = 1'b1; ef_d = 1'b1; lock_d = 1'b1;
            mode_d = RD_STATUS; state_d = ST_IDLE;
          end
        end
      end
      ST_LOAD: begin
        if (gap_expired) begin
          start_d = 1'b1; state_d = ST_ERS_BUSY;
        end else if (wr_ok) begin
          push_d = 1'b1; addr_d = wr_addr_i; load_clr = 1'b1;
        end
      end
      ST_PGM_BUSY: begin
        if (job_done_i) begin
          state_d = ST_IDLE; mode_d = RD_STATUS;
          if (job_fail_i) begin
            pf_d = 1'b1; lock_d = 1'b1;
          end
        end
      end
      ST_ERS_BUSY: begin
        if (job_done_i) begin
          state_d = ST_IDLE; mode_d = RD_STATUS;
          if (job_fail_i) begin
            ef_d = 1'b1; lock_d = 1'b1;
          end
        end else if (wr_ok && cmd == CMD_SUSPEND && susp_ok) begin
          state_d = ST_SUSP; mode_d = RD_STATUS;
        end
      end
      ST_SUSP: begin
        if (wr_ok) begin
          unique case (cmd)
            CMD_READ_ARRAY: mode_d = RD_ARRAY;
            CMD_STATUS:     mode_d = RD_STATUS;
            CMD_CONFIRM_D0: state_d = ST_ERS_BUSY;
            default: ;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  mode_q <= RD_ARRAY; kind_q <= JOB_PROG;
      lock_q  <= 1'b0;     ff_q   <= 1'b0;
      addr_q  <= '0;       data_q <= '0;
      start_q <= 1'b0; push_q <= 1'b0;
      pf_q <= 1'b0; ef_q <= 1'b0; vf_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      state_q <= state_d;  mode_q <= mode_d; kind_q <= kind_d;
      lock_q  <= lock_d;   ff_q   <= ff_d;
      addr_q  <= addr_d;   data_q <= data_d;
      start_q <= start_d; push_q <= push_d;
      pf_q <= pf_d; ef_q <= ef_d; vf_q <= vf_d; clr_q <= clr_d;
    end
  end

  assign rd_mode_o        = mode_q;
  assign job_start_o      = start_q;
  assign job_kind_o       = kind_q;
  assign job_addr_o       = addr_q;
  assign job_data_o       = data_q;
  assign blk_push_o       = push_q;
  assign susp_o           = (state_q == ST_SUSP);
  assign set_prog_fail_o  = pf_q;
  assign set_erase_fail_o = ef_q;
  assign set_vpp_fail_o   = vf_q;
  assign clr_status_o     = clr_q;

  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_o |=> !job_start_o);

  // R7
  pgm_busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PGM_BUSY && !job_done_i) |=>
      (!job_start_o && !clr_status_o && $stable(rd_mode_o)));

  // R8
  susp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_o) |-> $past(wr_i && cmd == CMD_SUSPEND && !vpp_lockout_i));

  // R9
  clear_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_o |-> $past(wr_i && cmd == CMD_CLEAR && !vpp_lockout_i));

  // R10
  lockout_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && vpp_lockout_i && !job_done_i) |=>
      (!blk_push_o && !clr_status_o && !set_vpp_fail_o && $stable(rd_mode_o)));

  // R11
  vpp_fail_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_vpp_fail_o |-> ((set_prog_fail_o || set_erase_fail_o) && !job_start_o));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int LOAD_CYC = 125 * 30;
  localparam int HOLD_CYC = 125 * 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic [16:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        vpp_lockout_i = 1'b0;
  logic        vpp_ok_i = 1'b1;
  logic        id_sel_i = 1'b0;
  logic        job_busy_i = 1'b0;
  logic        job_done_i = 1'b0;
  logic        job_fail_i = 1'b0;
  logic [1:0]  rd_mode_o;
  logic [15:0] id_data_o;
  logic        job_start_o;
  logic [2:0]  job_kind_o;
  logic [16:0] job_addr_o;
  logic [15:0] job_data_o;
  logic        blk_push_o, susp_o;
  logic        set_prog_fail_o, set_erase_fail_o, set_vpp_fail_o, clr_status_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .vpp_lockout_i(vpp_lockout_i), .vpp_ok_i(vpp_ok_i),
    .id_sel_i(id_sel_i), .job_busy_i(job_busy_i), .job_done_i(job_done_i),
    .job_fail_i(job_fail_i), .rd_mode_o(rd_mode_o), .id_data_o(id_data_o),
    .job_start_o(job_start_o), .job_kind_o(job_kind_o), .job_addr_o(job_addr_o),
    .job_data_o(job_data_o), .blk_push_o(blk_push_o), .susp_o(susp_o),
    .set_prog_fail_o(set_prog_fail_o), .set_erase_fail_o(set_erase_fail_o),
    .set_vpp_fail_o(set_vpp_fail_o), .clr_status_o(clr_status_o)
  );

  // {command byte, expected read mode}
  localparam logic [9:0] VEC [0:7] = '{
    {8'h70, 2'd1}, {8'hFF, 2'd0}, {8'h90, 2'd2}, {8'h70, 2'd1},
    {8'hD0, 2'd1}, {8'hB0, 2'd1}, {8'hA0, 2'd3}, {8'hFF, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns one cycle later
  task automatic wr(input logic [15:0] d, input logic [16:0] a);
    wr_i = 1'b1; wr_data_i = d; wr_addr_i = a;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic finish_job(input logic fail);
    job_done_i = 1'b1; job_fail_i = fail;
    @(negedge clk);
    job_done_i = 1'b0; job_fail_i = 1'b0; job_busy_i = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {set_vpp_fail_o, set_erase_fail_o, set_prog_fail_o, job_start_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", rd_mode_o, 0);
    chk("R1 outs", {susp_o, job_start_o, blk_push_o, clr_status_o, flags()}, 0);

    // R2 read-mode table (R8: D0h and B0h with nothing running have no effect)
    for (int i = 0; i < 8; i++) begin
      wr({8'h00, VEC[i][9:2]}, 17'h0);
      chk("R2 table mode", rd_mode_o, VEC[i][1:0]);
    end

    // R2 identifier and verify address
    wr(16'h0090, 17'h0);
    id_sel_i = 1'b0; #1;
    chk("R2 id mfr", id_data_o, 16'h00A5);
    id_sel_i = 1'b1; #1;
    chk("R2 id dev", id_data_o, 16'h003C);
    @(negedge clk);
    wr(16'h00A0, 17'h0123);
    chk("R2 verify", {rd_mode_o, job_addr_o}, {2'd3, 17'h0123});

    // R3 program
    wr(16'h0040, 17'h0);
    wr(16'hBEEF, 17'h0055);
    chk("R3 start", {job_start_o, job_kind_o, job_addr_o, job_data_o},
        {1'b1, 3'd0, 17'h0055, 16'hBEEF});
    chk("R3 mode", rd_mode_o, 1);
    job_busy_i = 1'b1;
    // R7 program busy ignores everything
    wr(16'h0090, 17'h0);
    chk("R7 pgm ignore mode", rd_mode_o, 1);
    wr(16'h0050, 17'h0);
    chk("R7 pgm ignore clr", clr_status_o, 0);
    wr(16'h00B0, 17'h0);
    chk("R7 pgm ignore susp", susp_o, 0);
    finish_job(1'b0);
    chk("R12 done ok", {rd_mode_o, flags()}, {2'd1, 4'b0});
    wr(16'h0010, 17'h0);
    wr(16'h00FF, 17'h0);
    chk("R3 abort", {rd_mode_o, flags()}, {2'd0, 4'b0});

    // R4 erase pairs
    wr(16'h0020, 17'h0);
    wr(16'h0020, 17'h0);
    chk("R4 chip", {job_start_o, job_kind_o}, {1'b1, 3'd1});
    job_busy_i = 1'b1;
    wr(16'h0090, 17'h0);
    chk("R7 erase ignore", rd_mode_o, 1);
    finish_job(1'b0);
    wr(16'h0060, 17'h0);
    wr(16'h0060, 17'h0077);
    chk("R4 block", {job_start_o, job_kind_o, job_addr_o}, {1'b1, 3'd2, 17'h0077});
    job_busy_i = 1'b1;
    finish_job(1'b0);
    wr(16'h0030, 17'h0);
    wr(16'h0030, 17'h0);
    chk("R4 auto chip", {job_start_o, job_kind_o}, {1'b1, 3'd3});
    job_busy_i = 1'b1;
    finish_job(1'b0);

    // R5 abort and mismatch
    wr(16'h0020, 17'h0);
    wr(16'h00FF, 17'h0);
    wr(16'h00FF, 17'h0);
    chk("R5 abort", {rd_mode_o, flags()}, {2'd0, 4'b0});
    wr(16'h0030, 17'h0);
    wr(16'h0070, 17'h0);
    chk("R5 mismatch", {rd_mode_o, flags()}, {2'd1, 4'b0110});

    // R9 lock
    wr(16'h0090, 17'h0);
    chk("R9 locked ident", rd_mode_o, 1);
    wr(16'h0010, 17'h0);
    wr(16'h1234, 17'h0);
    chk("R9 locked pgm", job_start_o, 0);
    wr(16'h00FF, 17'h0);
    chk("R9 locked array", rd_mode_o, 0);
    wr(16'h0050, 17'h0);
    chk("R9 clear", clr_status_o, 1);
    wr(16'h0090, 17'h0);
    chk("R9 unlocked", rd_mode_o, 2);

    // R10 lockout
    vpp_lockout_i = 1'b1;
    wr(16'h0070, 17'h0);
    chk("R10 mode", rd_mode_o, 2);
    wr(16'h0050, 17'h0);
    chk("R10 clr", clr_status_o, 0);
    vpp_lockout_i = 1'b0;

    // R11 supply fail on confirm
    vpp_ok_i = 1'b0;
    wr(16'h0020, 17'h0);
    wr(16'h0020, 17'h0);
    chk("R11 erase", flags(), 4'b1100);
    wr(16'h0050, 17'h0);
    wr(16'h0010, 17'h0);
    wr(16'h5555, 17'h0003);
    chk("R11 pgm", flags(), 4'b1010);
    wr(16'h0050, 17'h0);
    vpp_ok_i = 1'b1;

    // R6 block address window
    wr(16'h0020, 17'h0);
    wr(16'h00D0, 17'h0100);
    chk("R6 first push", {blk_push_o, job_start_o, job_addr_o}, {2'b10, 17'h0100});
    repeat (LOAD_CYC - 2) @(negedge clk);
    wr(16'h0000, 17'h0200);
    chk("R6 late push", {blk_push_o, job_addr_o}, {1'b1, 17'h0200});
    repeat (LOAD_CYC - 1) @(negedge clk);
    chk("R6 not yet", job_start_o, 0);
    @(negedge clk);
    chk("R6 start", {job_start_o, job_kind_o}, {1'b1, 3'd4});
    job_busy_i = 1'b1;

    // R8 suspend
    wr(16'h00B0, 17'h0);
    chk("R8 early susp", susp_o, 0);
    repeat (HOLD_CYC) @(negedge clk);
    wr(16'h00B0, 17'h0);
    chk("R8 susp", {susp_o, rd_mode_o}, {1'b1, 2'd1});
    wr(16'h0090, 17'h0);
    chk("R8 susp filter", rd_mode_o, 1);
    wr(16'h00FF, 17'h0);
    chk("R8 susp array", rd_mode_o, 0);
    wr(16'h0020, 17'h0);
    chk("R8 susp stays", susp_o, 1);
    wr(16'h00D0, 17'h0);
    chk("R8 resume", susp_o, 0);

    // R12 failing job
    finish_job(1'b1);
    chk("R12 fail", {rd_mode_o, flags()}, {2'd1, 4'b0100});
    wr(16'h0090, 17'h0);
    chk("R12 locked", rd_mode_o, 1);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule